// File: doc/BRIEF.md
# Receive Endpoint Packet-Ready Controller

This block keeps the receive-side status of one OUT endpoint. It holds an eight-bit control register and a packet-ready flag. The protocol side reports each accepted packet with a strobe, the packet's byte count and the free FIFO space left after it. The unload side reports FIFO reads: single-byte reads by the CPU and four-byte word reads by a DMA engine. Both are plain strobes.

While a packet is ready, the block counts the bytes that have been unloaded. When automatic clearing is enabled and the packet was exactly the programmed maximum size, the flag drops on its own once the count reaches that size. A shorter packet always waits for software to clear it. The block also raises a DMA request, gated by an enable bit and shaped by a mode bit. For each accepted bulk/interrupt packet it returns a handshake choice, ACK or NYET. It latches an incomplete-packet flag when the protocol side reports missing data.

Top module: `rx_ep_ready_ctrl`

## Requirements
- R1: With control bit 7 (auto-clear) at 1 and a packet whose byte count equals `maxPktBytes`, `pktRdy` falls on the clock edge at which the unloaded byte count reaches or passes `maxPktBytes`.
- R2: A packet shorter than `maxPktBytes` never clears `pktRdy` automatically, however many reads follow. A `swClrPktRdy` pulse clears it on the next edge.
- R3: Each `cpuRdByte` pulse adds 1 to the unloaded count and each `dmaRdWord` pulse adds 4, whatever `maxPktBytes` is. Reads while `pktRdy` is 0 are not counted.
- R4: Control bit 6 (isochronous) reads back as written while `hostMode` is 0, and reads as 0 while `hostMode` is 1.
- R5: With control bit 4 (no-NYET) at 1, every accepted bulk/interrupt packet gets an ACK (`hsValid`=1, `hsNyet`=0), including one that leaves the FIFO full.
- R6: With bit 4 at 0, a high-speed bulk/interrupt packet that leaves `fifoFreeBytes < maxPktBytes` gets NYET. Every other accepted bulk/interrupt packet gets ACK. The handshake appears on the edge after acceptance.
- R7: Control bit 0 (incomplete) is set by hardware when a packet is accepted with `pktPartial`=1. A register write with bit 0 at 0 clears it, and a write with bit 0 at 1 leaves it unchanged.
- R8: `dmaReq` is 0 whenever control bit 5 (DMA enable) is 0. With bit 5 at 1 and bit 3 (DMA mode) at 0, `dmaReq` follows `pktRdy`. With bit 3 at 1, `dmaReq` is 1 only while `pktRdy` is 1 and the current packet is maximum-size.
- R9: The unloaded count restarts from 0 on a software clear, on an automatic clear, and on each newly accepted packet.
- R10: After reset every register bit, `pktRdy`, `dmaReq` and `hsValid` are 0. Bits 2 and 1 always read 0 and ignore writes.
- R11: With bit 7 at 0, `pktRdy` is never cleared automatically, even for a maximum-size packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostMode | input | 1 | 1 when the controller acts as host |
| highSpeed | input | 1 | 1 when the link runs at high speed |
| maxPktBytes | input | SIZE_W | Programmed maximum packet size in bytes |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register readback |
| pktAccept | input | 1 | A received packet has been accepted into the FIFO |
| pktBytes | input | SIZE_W | Byte count of the accepted packet |
| pktBulkInt | input | 1 | Accepted packet is bulk or interrupt |
| pktPartial | input | 1 | Accepted high-bandwidth packet lacks part of its data |
| fifoFreeBytes | input | FREE_W | FIFO free space after the accepted packet |
| swClrPktRdy | input | 1 | Software clear of the packet-ready flag |
| cpuRdByte | input | 1 | One byte unloaded by the CPU |
| dmaRdWord | input | 1 | One four-byte word unloaded by DMA |
| pktRdy | output | 1 | Packet-ready flag |
| dmaReq | output | 1 | DMA request |
| hsValid | output | 1 | A handshake decision is presented this cycle |
| hsNyet | output | 1 | 1 selects NYET, 0 selects ACK |

## Verification
Directed runs drain a maximum-size packet with byte reads only and with word reads only. The flag must drop on exactly the 64th byte read or the 16th word read, which separates the two increments from each other and from an off-by-one compare. A short packet over-read, and a software clear partway through followed by a fresh packet, show whether the size gate and the counter restart work. Random runs change the maximum size (including one not divisible by four), mix packet sizes, read types and clears, and compare `pktRdy` and `dmaReq` every cycle against a bench model under each auto-clear and DMA-mode setting.

// File: rtl/rxep_pkg.sv
package rxep_pkg;
  typedef struct packed {
    logic clr;
    logic addByte;
    logic addWord;
    logic armAuto;
  } cntCmd_t;

  typedef struct packed {
    logic autoClr;
    logic iso;
    logic dmaEn;
    logic noNyet;
    logic dmaMode;
    logic incomp;
  } ctrlReg_t;
endpackage

// File: rtl/rxep_unload_dp.sv
module rxep_unload_dp
  import rxep_pkg::*;
#(
  parameter int SIZE_W    = 11,
  parameter int DMA_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntCmd_t           cmd,
  input  logic [SIZE_W-1:0] maxPkt,
  output logic              drainHit
);
  localparam int CNT_W = SIZE_W + 2;

  logic [CNT_W-1:0] unloadCnt;
  logic [CNT_W-1:0] incAmt;
  logic [CNT_W-1:0] sumCnt;

  always_comb begin
    incAmt = '0;
    if (cmd.addByte) incAmt = incAmt + CNT_W'(1);
    if (cmd.addWord) incAmt = incAmt + CNT_W'(DMA_BYTES);
    sumCnt   = unloadCnt + incAmt;
    drainHit = cmd.armAuto && (cmd.addByte || cmd.addWord) &&
               (sumCnt >= CNT_W'(maxPkt));
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    unloadCnt <= '0;
    else if (cmd.clr || drainHit) unloadCnt <= '0;
    else                          unloadCnt <= sumCnt;
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.clr || drainHit) |=> (unloadCnt == '0)); // R9

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.addWord && !cmd.addByte && !cmd.clr && !drainHit) |=>
      (unloadCnt == $past(unloadCnt) + CNT_W'(DMA_BYTES))); // R3
endmodule

// File: rtl/rxep_ctrl.sv
module rxep_ctrl
  import rxep_pkg::*;
#(
  parameter int SIZE_W = 11,
  parameter int FREE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostMode,
  input  logic              highSpeed,
  input  logic [SIZE_W-1:0] maxPktBytes,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              pktAccept,
  input  logic [SIZE_W-1:0] pktBytes,
  input  logic              pktBulkInt,
  input  logic              pktPartial,
  input  logic [FREE_W-1:0] fifoFreeBytes,
  input  logic              swClrPktRdy,
  input  logic              cpuRdByte,
  input  logic              dmaRdWord,
  input  logic              drainHit,
  output cntCmd_t           cmd,
  output logic              pktRdy,
  output logic              dmaReq,
  output logic              hsValid,
  output logic              hsNyet
);
  ctrlReg_t ctrlReg;
  logic     curMax;
  logic     roomShort;

  assign roomShort = (FREE_W + 1)'(fifoFreeBytes) < (FREE_W + 1)'(maxPktBytes);

  always_comb begin
    cmd.clr     = pktAccept || swClrPktRdy;
    cmd.addByte = cpuRdByte && pktRdy;
    cmd.addWord = dmaRdWord && pktRdy;
    cmd.armAuto = ctrlReg.autoClr && curMax && pktRdy && !cmd.clr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else begin
      if (regWrEn) begin
        ctrlReg.autoClr <= regWrData[7];
        ctrlReg.iso     <= regWrData[6];
        ctrlReg.dmaEn   <= regWrData[5];
        ctrlReg.noNyet  <= regWrData[4];
        ctrlReg.dmaMode <= regWrData[3];
        if (!regWrData[0]) ctrlReg.incomp <= 1'b0;
      end
      if (pktAccept && pktPartial) ctrlReg.incomp <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktRdy <= 1'b0;
      curMax <= 1'b0;
    end else if (pktAccept) begin
      pktRdy <= 1'b1;
      curMax <= (pktBytes == maxPktBytes);
    end else if (swClrPktRdy || drainHit) begin
      pktRdy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsValid <= 1'b0;
      hsNyet  <= 1'b0;
    end else begin
      hsValid <= pktAccept && pktBulkInt;
      hsNyet  <= pktAccept && pktBulkInt && highSpeed &&
                 !ctrlReg.noNyet && roomShort;
    end
  end

  assign regRdData = {ctrlReg.autoClr, ctrlReg.iso && !hostMode,
                      ctrlReg.dmaEn, ctrlReg.noNyet, ctrlReg.dmaMode,
                      2'b00, ctrlReg.incomp};

  assign dmaReq = ctrlReg.dmaEn && pktRdy && (!ctrlReg.dmaMode || curMax);

  AST_AUTO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (drainHit && !pktAccept) |=> !pktRdy); // R1

  AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pktRdy && !curMax && !swClrPktRdy && !pktAccept) |=> pktRdy); // R2

  AST_NO_NYET: assert property (@(posedge clk) disable iff (!rstN)
    (pktAccept && ctrlReg.noNyet) |=> !hsNyet); // R5

  AST_PARTIAL_SET: assert property (@(posedge clk) disable iff (!rstN)
    (pktAccept && pktPartial) |=> regRdData[0]); // R7

  AST_DMA_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !pktRdy |-> !dmaReq); // R8
endmodule

// File: rtl/rx_ep_ready_ctrl.sv
module rx_ep_ready_ctrl
  import rxep_pkg::*;
#(
  parameter int SIZE_W = 11,
  parameter int FREE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostMode,
  input  logic              highSpeed,
  input  logic [SIZE_W-1:0] maxPktBytes,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              pktAccept,
  input  logic [SIZE_W-1:0] pktBytes,
  input  logic              pktBulkInt,
  input  logic              pktPartial,
  input  logic [FREE_W-1:0] fifoFreeBytes,
  input  logic              swClrPktRdy,
  input  logic              cpuRdByte,
  input  logic              dmaRdWord,
  output logic              pktRdy,
  output logic              dmaReq,
  output logic              hsValid,
  output logic              hsNyet
);
  cntCmd_t cmd;
  logic    drainHit;

  rxep_ctrl #(.SIZE_W(SIZE_W), .FREE_W(FREE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostMode(hostMode), .highSpeed(highSpeed),
    .maxPktBytes(maxPktBytes), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .pktAccept(pktAccept), .pktBytes(pktBytes),
    .pktBulkInt(pktBulkInt), .pktPartial(pktPartial),
    .fifoFreeBytes(fifoFreeBytes), .swClrPktRdy(swClrPktRdy),
    .cpuRdByte(cpuRdByte), .dmaRdWord(dmaRdWord), .drainHit(drainHit),
    .cmd(cmd), .pktRdy(pktRdy), .dmaReq(dmaReq), .hsValid(hsValid),
    .hsNyet(hsNyet)
  );

  rxep_unload_dp #(.SIZE_W(SIZE_W), .DMA_BYTES(4)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .maxPkt(maxPktBytes),
    .drainHit(drainHit)
  );
endmodule

// File: tb/rx_ep_ready_ctrl_tb.sv
module rx_ep_ready_ctrl_tb;
  localparam int SIZE_W = 11;
  localparam int FREE_W = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostMode = 0, highSpeed = 0, regWrEn = 0;
  logic [7:0] regWrData = 0, regRdData;
  logic [SIZE_W-1:0] maxPktBytes = 64, pktBytes = 0;
  logic pktAccept = 0, pktBulkInt = 0, pktPartial = 0;
  logic [FREE_W-1:0] fifoFreeBytes = 0;
  logic swClrPktRdy = 0, cpuRdByte = 0, dmaRdWord = 0;
  logic pktRdy, dmaReq, hsValid, hsNyet;

  int checks = 0, errors = 0;
  bit done = 0;
  // bench model
  bit mRdy = 0, mMax = 0;
  int mCnt = 0;
  logic [7:0] cfg = 0;

  always #10 clk = ~clk;

  rx_ep_ready_ctrl #(.SIZE_W(SIZE_W), .FREE_W(FREE_W)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit expDma(logic [7:0] c, bit rdy, bit mx);
    return c[5] && rdy && (!c[3] || mx);
  endfunction

  // apply current strobes at next edge, update model, then drop strobes
  task automatic tick();
    bit acc = pktAccept, clr = swClrPktRdy;
    int inc = (cpuRdByte ? 1 : 0) + (dmaRdWord ? 4 : 0);
    @(posedge clk); #2;
    if (regWrEn) cfg = regWrData;
    if (acc) begin mRdy = 1; mCnt = 0; mMax = (pktBytes == maxPktBytes); end
    else if (clr) begin mRdy = 0; mCnt = 0; end
    else if (mRdy) begin
      mCnt += inc;
      if (cfg[7] && mMax && inc > 0 && mCnt >= maxPktBytes) begin mRdy = 0; mCnt = 0; end
    end
    regWrEn = 0; pktAccept = 0; swClrPktRdy = 0; cpuRdByte = 0; dmaRdWord = 0;
    pktPartial = 0;
  endtask

  task automatic wr(logic [7:0] d);
    regWrEn = 1; regWrData = d; tick();
  endtask

  task automatic accept(int n);
    pktAccept = 1; pktBytes = SIZE_W'(n); tick();
  endtask

  task automatic reads(int n, bit word);
    for (int i = 0; i < n; i++) begin
      if (word) dmaRdWord = 1; else cpuRdByte = 1;
      tick();
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rstN = 1; #2;
    chk("R10 reg reset", regRdData, 0);
    chk("R10 pktRdy reset", pktRdy, 0);
    chk("R10 dmaReq reset", dmaReq, 0);
    chk("R10 hsValid reset", hsValid, 0);

    wr(8'hFF);
    chk("R10 reserved bits and incomp write-1", regRdData, 8'hF8);
    hostMode = 1; #1;
    chk("R4 iso reads 0 in host", regRdData, 8'hB8);
    hostMode = 0; #1;
    chk("R4 iso visible in device", regRdData[6], 1);

    wr(8'h80);
    accept(64);
    reads(63, 0);
    chk("R1 still ready after 63 bytes", pktRdy, 1);
    reads(1, 0);
    chk("R1 auto-clear at 64 bytes", pktRdy, 0);

    accept(64);
    reads(15, 1);
    chk("R3 ready after 15 words", pktRdy, 1);
    reads(1, 1);
    chk("R3 clear after 16 words", pktRdy, 0);
    reads(3, 0);
    chk("R3 reads while idle ignored", pktRdy, 0);

    accept(20);
    reads(70, 0);
    chk("R2 short packet holds", pktRdy, 1);
    swClrPktRdy = 1; tick();
    chk("R2 software clear", pktRdy, 0);

    accept(64);
    reads(10, 0);
    swClrPktRdy = 1; tick();
    accept(64);
    reads(63, 0);
    chk("R9 count restarted", pktRdy, 1);
    reads(1, 0);
    chk("R9 clear at full count", pktRdy, 0);

    wr(8'h00);
    accept(64);
    reads(80, 0);
    chk("R11 no auto-clear when disabled", pktRdy, 1);
    chk("R8 dmaReq off when disabled", dmaReq, 0);
    swClrPktRdy = 1; tick();

    wr(8'h20); accept(20);
    chk("R8 mode0 follows pktRdy", dmaReq, 1);
    wr(8'h28);
    chk("R8 mode1 short packet", dmaReq, 0);
    accept(64);
    chk("R8 mode1 max packet", dmaReq, 1);
    swClrPktRdy = 1; tick();
    chk("R8 no request when not ready", dmaReq, 0);

    wr(8'h00);
    highSpeed = 1; pktBulkInt = 1; fifoFreeBytes = 10; accept(64);
    chk("R6 nyet valid", hsValid, 1);
    chk("R6 nyet when room short", hsNyet, 1);
    fifoFreeBytes = 200; accept(64);
    chk("R6 ack with room", hsNyet, 0);
    highSpeed = 0; fifoFreeBytes = 0; accept(64);
    chk("R6 ack at full speed", hsNyet, 0);
    wr(8'h10);
    highSpeed = 1; fifoFreeBytes = 0; accept(64);
    chk("R5 ack on full FIFO", hsNyet, 0);
    chk("R5 handshake valid", hsValid, 1);

    pktPartial = 1; accept(64);
    chk("R7 incomplete set", regRdData[0], 1);
    wr(8'h11);
    chk("R7 write 1 keeps", regRdData[0], 1);
    wr(8'h10);
    chk("R7 write 0 clears", regRdData[0], 0);
    swClrPktRdy = 1; tick();

    // random phase against model, R1 R2 R3 R8 R9 R11
    for (int seg = 0; seg < 8; seg++) begin
      maxPktBytes = (seg % 3 == 0) ? 64 : (seg % 3 == 1) ? 30 : 12;
      wr({seg[0], 1'b0, 1'b1, 1'b0, seg[1], 3'b000});
      for (int c = 0; c < 1500; c++) begin
        int r = $urandom_range(0, 99);
        if (r < 6) begin
          pktAccept = 1;
          pktBytes = ($urandom_range(0, 1) == 1) ? maxPktBytes
                     : SIZE_W'($urandom_range(1, maxPktBytes - 1));
        end else if (r < 9) swClrPktRdy = 1;
        else begin
          cpuRdByte = ($urandom_range(0, 2) == 0);
          dmaRdWord = ($urandom_range(0, 2) == 0);
        end
        tick();
        chk("R1 R2 R3 R9 R11 random pktRdy", pktRdy, mRdy);
        chk("R8 random dmaReq", dmaReq, expDma(cfg, mRdy, mMax));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule